// File: doc/BRIEF.md
# Two-Wire Register Target with Alert Reply

This block is a target on a two-wire serial bus (I2C / SMBus) that exposes a bank of four byte-wide registers. It accepts the single-byte write and single-byte read transactions of the SMBus protocol. It also answers the shared alert-reply address whenever it has an alert pending. SCL and SDA arrive as raw samples taken on the system clock. Each line is first synchronised and then deglitched. Only after that does the protocol engine see START, STOP and clock edges. The target drives the bus through a single open-drain pull-down for SDA and never holds SCL low.

Its own 7-bit address is a fixed `10` prefix followed by five strap inputs. A command byte loads a two-bit register pointer, and a following data byte writes the chosen register. A repeated START with the read bit set returns the chosen register. Register 1 is special. Its two low bits drive the GPIO outputs. Two further bits report the pin levels after synchronisation, so software can see a pin held low by another device while its driver is releasing it. All ports are plain level signals. The bus cannot be stalled, because the target does not stretch the clock, so no handshake or back-pressure exists at any port.

Top module: `smb_regslave`

## Requirements
- R1: The target answers only the 7-bit address formed from the bits 1, 0, then strap[4:0], sent MSB first. For any other address it gives no ACK, and its SDA pull-down stays off until the next START.
- R2: Only bits [1:0] of the command byte select the register. Bits [7:2] have no effect on which register is accessed.
- R3: A write transaction stores the data byte in the selected register. The sequence is START, address with R/W = 0, command byte, data byte, with each of the three bytes ACKed. Register i appears on regs_o[8*i+7:8*i].
- R4: A read transaction returns the selected register MSB first. The sequence is START, address with R/W = 0, command byte, repeated START, address with R/W = 1, all ACKed, then the data byte, the host's NACK and STOP.
- R5: With an alert pending, the target ACKs the address 0001100 with R/W = 1 and replies with the byte {1, 0, strap[4:0], 0}.
- R6: With no alert pending, the target does not ACK the alert-reply address. A pending alert is cleared once the 8 bits of the reply byte have been sent.
- R7: The target ignores pulses on SCL or SDA lasting fewer than FILT_LEN system clocks. With the default of 6 clocks at 100 MHz, this rejects pulses of 50 ns or less.
- R8: In register 1, bits [1:0] are written by the host and drive gpio_drv_o. Bits [3:2] read gpio_pin_i[1:0] through a two-flop synchroniser. Bits [7:4] read 0, and writes to bits [7:2] are ignored.
- R9: A STOP inside a byte returns the target to idle with no register written. A START inside a byte begins a new address byte.
- R10: sda_pull_o changes only while SCL is low. The ACK pull-down lasts from the SCL fall after bit 8 to the SCL fall after bit 9.
- R11: After reset all stored register bits are 0, sda_pull_o is 0 and gpio_drv_o is 0.
- R12: A pending alert is set by a rising edge of alert_i. Holding alert_i high does not set it again after it has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain) |
| addr_strap_i | input | 5 | Low five bits of the target address |
| alert_i | input | 1 | Alert request, rising edge arms a pending alert |
| gpio_pin_i | input | 2 | Sampled GPIO pin levels |
| gpio_drv_o | output | 2 | GPIO driver state from register 1 bits [1:0] |
| regs_o | output | 32 | Read value of all four registers, register i in bits [8i+7:8i] |

## Verification
Two things coincide on the SCL falling edge that ends the address ACK of a read. The ACK pull-down must end, and the first data bit must start driving on that same fall. When bit 7 of the data is 0, the pull-down must stay on with no gap. When bit 7 is 1, it must be released at once. The bench provokes both cases by reading registers and alert replies whose top bit differs (0xA5, 0x81, 0x07 and the 0xAC reply). It judges them from the bit seen on the line in the middle of each SCL high phase, and it checks on every clock that the pull-down never moves while SCL is high.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;
  localparam logic [1:0] DEV_PREFIX = 2'b10;
  localparam logic [6:0] ALERT_REPLY_ADDR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_TX,
    ST_WAIT
  } smb_state_e;
endpackage

// File: rtl/smb_deglitch.sv
// Two-flop synchroniser followed by a persistence filter: the output
// follows the input only after it has differed for LEN clocks in a row.
module smb_deglitch #(
  parameter int LEN = 6,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(LEN + 1);

  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= RST_VAL;
      s2   <= RST_VAL;
      dout <= RST_VAL;
      cnt  <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (s2 == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(LEN - 1)) begin
        dout <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smb_sync2.sv
module smb_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      dout <= '0;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smb_pkg::*;
#(
  parameter int NREG = 4,
  parameter int GPIO_W = 2,
  parameter int GPIO_IDX = 1,
  localparam int PW = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [PW-1:0]          wr_ptr,
  input  logic [BYTE_W-1:0]      wr_data,
  input  logic [PW-1:0]          rd_ptr,
  input  logic [GPIO_W-1:0]      pin_sync,
  output logic [BYTE_W-1:0]      rd_data,
  output logic [NREG*BYTE_W-1:0] regs_o,
  output logic [GPIO_W-1:0]      gpio_drv_o
);
  localparam int PAD_W = BYTE_W - 2 * GPIO_W;

  logic [BYTE_W-1:0] val [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == GPIO_IDX) begin : g_gpio
      logic [GPIO_W-1:0] drv_q;
      always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= '0;
        else if (wr_en && wr_ptr == PW'(i)) drv_q <= wr_data[GPIO_W-1:0];
      end
      assign val[i] = {{PAD_W{1'b0}}, pin_sync, drv_q};
      assign gpio_drv_o = drv_q;
    end else begin : g_plain
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (wr_en && wr_ptr == PW'(i)) q <= wr_data;
      end
      assign val[i] = q;
    end
    assign regs_o[i*BYTE_W +: BYTE_W] = val[i];
  end

  assign rd_data = val[rd_ptr];
endmodule

// File: rtl/smb_engine.sv
// Protocol engine working on the filtered lines: START/STOP detection,
// byte shifting, address decode, ACK drive and reply transmission.
module smb_engine
  import smb_pkg::*;
#(
  parameter int NREG = 4,
  localparam int PW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [6:0]        dev_addr,
  input  logic              alert_pend,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [PW-1:0]     ptr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              ara_done,
  output smb_state_e        state_o,
  output logic              stop_o
);
  localparam logic [3:0] BITS = 4'd8;

  smb_state_e        state, nxt;
  logic              scl_q, sda_q;
  logic [3:0]        bitcnt;
  logic              ackph;
  logic              ara_tx;
  logic [BYTE_W-1:0] sreg, txsh;
  logic              addr_hit, ara_hit;
  logic              scl_rise, scl_fall, start_det, stop_det;

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

  always_comb begin
    addr_hit = (sreg[BYTE_W-1:1] == dev_addr);
    ara_hit  = (sreg[BYTE_W-1:1] == ALERT_REPLY_ADDR) && sreg[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      nxt      <= ST_IDLE;
      bitcnt   <= '0;
      ackph    <= 1'b0;
      ara_tx   <= 1'b0;
      sreg     <= '0;
      txsh     <= '0;
      ptr      <= '0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      ara_done <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      ara_done <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        bitcnt   <= '0;
        ackph    <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        bitcnt   <= '0;
        ackph    <= 1'b0;
        sda_pull <= 1'b0;
      end else if (ackph) begin
        if (scl_fall) begin
          ackph    <= 1'b0;
          bitcnt   <= '0;
          state    <= nxt;
          sda_pull <= (nxt == ST_TX) ? ~txsh[BYTE_W-1] : 1'b0;
        end
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise) begin
              sreg   <= {sreg[BYTE_W-2:0], sda_f};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == BITS) begin
              ackph    <= 1'b1;
              sda_pull <= 1'b1;
              case (state)
                ST_ADDR: begin
                  if (addr_hit && !sreg[0]) begin
                    nxt <= ST_CMD;
                  end else if (addr_hit) begin
                    nxt    <= ST_TX;
                    txsh   <= rd_data;
                    ara_tx <= 1'b0;
                  end else if (ara_hit && alert_pend) begin
                    nxt    <= ST_TX;
                    txsh   <= {dev_addr, 1'b0};
                    ara_tx <= 1'b1;
                  end else begin
                    ackph    <= 1'b0;
                    sda_pull <= 1'b0;
                    state    <= ST_WAIT;
                  end
                end
                ST_CMD: begin
                  ptr <= sreg[PW-1:0];
                  nxt <= ST_WDATA;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_data <= sreg;
                  nxt     <= ST_WAIT;
                end
              endcase
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == BITS) begin
              sda_pull <= 1'b0;
              state    <= ST_WAIT;
              ara_done <= ara_tx;
            end else if (scl_fall && bitcnt != 4'd0) begin
              txsh     <= {txsh[BYTE_W-2:0], 1'b0};
              sda_pull <= ~txsh[BYTE_W-2];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign state_o = state;
  assign stop_o  = stop_det;
endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
  import smb_pkg::*;
#(
  parameter int NREG = 4,
  parameter int GPIO_W = 2,
  parameter int GPIO_IDX = 1,
  parameter int FILT_LEN = 6,
  localparam int PW = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_pull_o,
  input  logic [4:0]             addr_strap_i,
  input  logic                   alert_i,
  input  logic [GPIO_W-1:0]      gpio_pin_i,
  output logic [GPIO_W-1:0]      gpio_drv_o,
  output logic [NREG*BYTE_W-1:0] regs_o
);
  logic [1:0]        raw_lines, filt_lines;
  logic              scl_f, sda_f;
  logic [GPIO_W-1:0] pin_sync;
  logic              wr_en, ara_done, eng_stop;
  logic [PW-1:0]     wr_ptr;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic              alert_q, alert_pend;
  smb_state_e        eng_state;
  logic [6:0]        dev_addr;

  assign raw_lines = {scl_i, sda_i};
  assign dev_addr  = {DEV_PREFIX, addr_strap_i};

  for (genvar g = 0; g < 2; g++) begin : g_flt
    smb_deglitch #(.LEN(FILT_LEN), .RST_VAL(1'b1)) u_flt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines[g]),
      .dout (filt_lines[g])
    );
  end
  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  smb_sync2 #(.W(GPIO_W)) u_pin_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (gpio_pin_i),
    .dout (pin_sync)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alert_q    <= 1'b0;
      alert_pend <= 1'b0;
    end else begin
      alert_q <= alert_i;
      if (alert_i && !alert_q) alert_pend <= 1'b1;
      else if (ara_done) alert_pend <= 1'b0;
    end
  end

  smb_engine #(.NREG(NREG)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .dev_addr  (dev_addr),
    .alert_pend(alert_pend),
    .rd_data   (rd_data),
    .sda_pull  (sda_pull_o),
    .wr_en     (wr_en),
    .ptr       (wr_ptr),
    .wr_data   (wr_data),
    .ara_done  (ara_done),
    .state_o   (eng_state),
    .stop_o    (eng_stop)
  );

  smb_regbank #(.NREG(NREG), .GPIO_W(GPIO_W), .GPIO_IDX(GPIO_IDX)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .wr_data   (wr_data),
    .rd_ptr    (wr_ptr),
    .pin_sync  (pin_sync),
    .rd_data   (rd_data),
    .regs_o    (regs_o),
    .gpio_drv_o(gpio_drv_o)
  );
endmodule

// File: rtl/smb_regslave_chk.sv
module smb_regslave_chk
  import smb_pkg::*;
#(
  parameter int NREG = 4,
  parameter int GPIO_W = 2,
  parameter int GPIO_IDX = 1,
  localparam int PW = $clog2(NREG)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_f,
  input logic                   sda_pull_o,
  input smb_state_e             state,
  input logic                   stop_seen,
  input logic                   wr_en,
  input logic [PW-1:0]          wr_ptr,
  input logic [BYTE_W-1:0]      wr_data,
  input logic [NREG*BYTE_W-1:0] regs_o,
  input logic                   alert_pend,
  input logic                   ara_done
);
  // R10
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_pull_o));

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> (state == ST_IDLE && !sda_pull_o));

  // R1
  released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_WAIT) |-> !sda_pull_o);

  // R6
  alert_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_pend) |-> $past(ara_done));

  for (genvar i = 0; i < NREG; i++) begin : g_wr
    if (i == GPIO_IDX) begin : g_io
      // R8
      gpio_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr == PW'(i)) |=>
          regs_o[i*BYTE_W +: GPIO_W] == $past(wr_data[GPIO_W-1:0]));
    end else begin : g_pl
      // R3
      reg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr == PW'(i)) |=> regs_o[i*BYTE_W +: BYTE_W] == $past(wr_data));
    end
  end
endmodule

bind smb_regslave smb_regslave_chk #(
  .NREG(NREG), .GPIO_W(GPIO_W), .GPIO_IDX(GPIO_IDX)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_f     (scl_f),
  .sda_pull_o(sda_pull_o),
  .state     (eng_state),
  .stop_seen (eng_stop),
  .wr_en     (wr_en),
  .wr_ptr    (wr_ptr),
  .wr_data   (wr_data),
  .regs_o    (regs_o),
  .alert_pend(alert_pend),
  .ara_done  (ara_done)
);

// File: tb/smb_regslave_tb_top.sv
module smb_regslave_tb_top;
  localparam int Q = 64;
  localparam logic [31:0] BANK_MASK = 32'hFFFF_F3FF;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, scl_h, sda_h, alert, bus_idle;
  logic [4:0]  strap;
  logic [1:0]  pins, drv;
  logic [31:0] regs;
  logic        sda_pull_o;
  wire         sda_line = sda_h & ~sda_pull_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_regs [4];
  logic pull_prev, scl_prev;

  smb_regslave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .addr_strap_i(strap), .alert_i(alert),
    .gpio_pin_i(pins), .gpio_drv_o(drv), .regs_o(regs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_bank();
    return {m_regs[3], m_regs[2], 6'b0, m_regs[1][1:0], m_regs[0]};
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] idx);
    if (idx == 2'd1) return {4'b0, pins, m_regs[1][1:0]};
    return m_regs[idx];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_h && scl_prev) chk("R10 pull-down moved while SCL high", 32'(sda_pull_o), 32'(pull_prev));
      if (bus_idle) begin
        chk("R3 register bank contents", regs & BANK_MASK, exp_bank() & BANK_MASK);
        chk("R8 gpio driver bits", 32'(drv), 32'(m_regs[1][1:0]));
      end
    end
    pull_prev = sda_pull_o;
    scl_prev  = scl_h;
  end

  task automatic qwait(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic b_start();
    bus_idle = 1'b0;
    sda_h = 1'b1; qwait(Q);
    scl_h = 1'b1; qwait(Q);
    sda_h = 1'b0; qwait(Q);
    scl_h = 1'b0; qwait(Q);
  endtask

  task automatic b_stop();
    sda_h = 1'b0; qwait(Q);
    scl_h = 1'b1; qwait(Q);
    sda_h = 1'b1; qwait(Q);
  endtask

  task automatic settle();
    qwait(32);
    bus_idle = 1'b1;
  endtask

  task automatic b_bit(input logic b, input bit gl, output logic seen);
    sda_h = b; qwait(Q/2);
    if (gl) begin scl_h = 1'b1; qwait(4); scl_h = 1'b0; end else qwait(4);
    qwait(Q/2 - 4);
    scl_h = 1'b1; qwait(Q/2);
    if (gl) begin sda_h = ~b; qwait(4); sda_h = b; end else qwait(4);
    qwait(Q/2 - 4);
    seen = sda_line;
    qwait(Q);
    scl_h = 1'b0; qwait(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit gl, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) b_bit(b[i], gl, s);
    b_bit(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      b_bit(1'b1, 1'b0, s);
      d = {d[6:0], s};
    end
    b_bit(1'b1, 1'b0, s);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d,
                    input bit gl, input string req);
    logic hit, ack;
    hit = (a == {2'b10, strap});
    b_start();
    send_byte({a, 1'b0}, 1'b0, ack); chk({req, " address ACK"}, 32'(ack), 32'(hit));
    send_byte(cmd, gl, ack);         chk({req, " command ACK"}, 32'(ack), 32'(hit));
    send_byte(d, gl, ack);           chk({req, " data ACK"}, 32'(ack), 32'(hit));
    b_stop();
    if (hit) m_regs[cmd[1:0]] = (cmd[1:0] == 2'd1) ? {6'b0, d[1:0]} : d;
    settle();
  endtask

  task automatic rd(input logic [7:0] cmd, input string req);
    logic ack;
    logic [7:0] d;
    b_start();
    send_byte({2'b10, strap, 1'b0}, 1'b0, ack); chk({req, " write address ACK"}, 32'(ack), 32'd1);
    send_byte(cmd, 1'b0, ack);                  chk({req, " command ACK"}, 32'(ack), 32'd1);
    b_start();
    send_byte({2'b10, strap, 1'b1}, 1'b0, ack); chk({req, " read address ACK"}, 32'(ack), 32'd1);
    recv_byte(d);                               chk({req, " read data"}, 32'(d), 32'(exp_read(cmd[1:0])));
    b_stop();
    settle();
  endtask

  task automatic ara(input logic exp_ack, input string req);
    logic ack;
    logic [7:0] d;
    b_start();
    send_byte({7'b0001100, 1'b1}, 1'b0, ack); chk({req, " alert reply ACK"}, 32'(ack), 32'(exp_ack));
    if (ack) begin
      recv_byte(d); chk({req, " alert reply byte"}, 32'(d), 32'({2'b10, strap, 1'b0}));
    end
    b_stop();
    settle();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    qwait(195000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic ack, s;
    scl_h = 1'b1; sda_h = 1'b1; alert = 1'b0; pins = 2'b00; strap = 5'b10110;
    bus_idle = 1'b0; rst_n = 1'b0;
    for (int i = 0; i < 4; i++) m_regs[i] = 8'h00;
    qwait(10); rst_n = 1'b1; qwait(8);
    @(negedge clk);
    chk("R11 registers after reset", regs, 32'h0);
    chk("R11 pull-down after reset", 32'(sda_pull_o), 32'd0);
    chk("R11 gpio drive after reset", 32'(drv), 32'd0);
    bus_idle = 1'b1;

    wr({2'b10, strap}, 8'h00, 8'hA5, 1'b0, "R3 write reg0");
    rd(8'h00, "R4 read reg0");
    wr({2'b10, strap}, 8'hFE, 8'h3C, 1'b0, "R2 command FE selects reg2");
    rd(8'h02, "R2 read reg2");
    wr({2'b10, strap}, 8'h03, 8'h81, 1'b0, "R3 write reg3");
    rd(8'h07, "R2 command 07 reads reg3");
    rd(8'hFC, "R4 command FC reads reg0");

    wr({2'b10, strap}, 8'h01, 8'hFF, 1'b0, "R8 write reg1");
    pins = 2'b01; qwait(8);
    rd(8'h01, "R8 reg1 with pins 01");
    wr({2'b10, strap}, 8'h01, 8'h02, 1'b0, "R8 write reg1 drive 10");
    pins = 2'b00; qwait(8);
    rd(8'h01, "R8 reg1 pin pulled low externally");

    wr({2'b10, strap ^ 5'b00001}, 8'h00, 8'h11, 1'b0, "R1 strap mismatch");
    b_start();
    send_byte({2'b01, strap, 1'b0}, 1'b0, ack);
    chk("R1 prefix mismatch ACK", 32'(ack), 32'd0);
    b_stop(); settle();

    wr({2'b10, strap}, 8'h00, 8'h5E, 1'b1, "R7 glitched write reg0");
    chk("R7 reg0 after glitches", 32'(regs[7:0]), 32'h5E);

    b_start();
    send_byte({2'b10, strap, 1'b0}, 1'b0, ack);
    send_byte(8'h00, 1'b0, ack);
    for (int i = 0; i < 4; i++) b_bit(1'b1, 1'b0, s);
    b_stop(); settle();
    chk("R9 STOP mid-byte leaves reg0", 32'(regs[7:0]), 32'h5E);

    b_start();
    send_byte({2'b10, strap, 1'b0}, 1'b0, ack);
    send_byte(8'h02, 1'b0, ack);
    for (int i = 0; i < 3; i++) b_bit(1'b0, 1'b0, s);
    b_start();
    send_byte({2'b10, strap, 1'b0}, 1'b0, ack); chk("R9 address after mid-byte START", 32'(ack), 32'd1);
    send_byte(8'h02, 1'b0, ack);
    send_byte(8'h5A, 1'b0, ack);
    b_stop();
    m_regs[2] = 8'h5A;
    settle();
    chk("R9 reg2 written after restart", 32'(regs[23:16]), 32'h5A);

    ara(1'b0, "R6 no alert pending");
    alert = 1'b1; qwait(4);
    ara(1'b1, "R5 alert pending");
    ara(1'b0, "R12 level held, cleared after reply");
    alert = 1'b0; qwait(4); alert = 1'b1; qwait(4);
    ara(1'b1, "R12 new rising edge");

    summary();
    $finish;
  end
endmodule